// File: doc/BRIEF.md
# Programmable 14-bit Interval Timer

This block divides its clock by a programmable terminal count and shapes one output line from that division. A small byte-wide write port reaches three registers: a command register, a low count byte and a high count byte. The high byte carries the upper count bits and also the 2-bit waveform mode. The count runs only on cycles where the `tick` enable is high, so `tick` is the input clock being divided. The core clock `clk` samples everything.

There are four waveforms. The first is a square wave that runs once. The second is a square wave that repeats. The third is a single low pulse at terminal count. The fourth is a low pulse at every terminal count. Software controls the timer through the 2-bit command field. A command can start the timer. It can halt the timer at once. It can let the current period finish and then stop. If the timer is already running, a start command swaps in the latest register contents at the next terminal count.

All pins are plain control pins. A write is taken in the cycle where `wr_en` is high, with no back-pressure. There is no read path.

Top module: `ptimer14`

## Requirements
- R1: During reset and after it, the timer is idle and `tmr_out` is 1. An idle timer holds `tmr_out` at 1.
- R2: Register addresses and fields:
  - Address 3'b100 takes count bits 7..0.
  - Address 3'b101 takes count bits 13..8 in data bits 5..0, and the mode in data bits 7..6.
  - Address 3'b000 is the command register, and the command is in data bits 7..6.
- R3: In the square-wave modes, each period of TC ticks begins high for (TC+1)/2 ticks, rounded down, and is then low for TC/2 ticks, rounded down.
- R4: Mode 2'b00 gives one square-wave period and then goes idle. Mode 2'b01 repeats the period until it is stopped.
- R5: In the pulse modes, `tmr_out` is 1 for the first TC-1 ticks of a period and 0 for the TC-th tick. Mode 2'b10 does this once and then goes idle. Mode 2'b11 repeats it.
- R6: Command 2'b00 has no effect. Command 2'b01 stops the timer at the next clock edge and drives `tmr_out` to 1.
- R7: Command 2'b10, given while the timer runs, lets the current period finish and then leaves the timer idle.
- R8: Command 2'b11 behaves in two ways:
  - When the timer is idle, it loads the count and mode from the registers and starts the count.
  - When the timer is running, the latest register values are loaded at the next terminal count, and the count continues in the new mode whatever the old mode was.
- R9: Writing the count bytes while the timer runs leaves the waveform in progress unchanged.
- R10: A programmed count of 0 or 1 acts as a count of 2.
- R11: The count advances only on clock edges where `tick` is 1. With `tick` at 0, `tmr_out` holds its value.
- R12: A command written in the terminal-count cycle takes effect at that terminal count:
  - A start reloads the count, even in a one-shot mode.
  - A finish-period command stops a repeating mode.
  - A halt stops the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; the clock being divided |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| tmr_out | output | 1 | Timer waveform output, idle high |

## Verification
A command write can land on the same edge as terminal count. In that case the command's effect must be merged with the reload-or-stop decision that terminal count makes. The bench times a start write, a finish-period write and a halt write so that each lands exactly on the edge where the count is 1. It then judges the outcome from the next few output samples:
- A start write must produce the new pulse pattern, where a stop would have left the line high.
- A finish-period write or a halt write must leave the line steadily high, where a reload would have shown the low pulse again.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int FLD_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 3'b000;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'b100;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'b101;

  typedef enum logic [FLD_W-1:0] {
    CMD_NOP   = 2'b00,
    CMD_HALT  = 2'b01,
    CMD_DRAIN = 2'b10,
    CMD_START = 2'b11
  } cmd_e;

  // bit 0: repeat, bit 1: pulse shape
  typedef enum logic [FLD_W-1:0] {
    WAVE_SQ_ONCE = 2'b00,
    WAVE_SQ_LOOP = 2'b01,
    WAVE_PL_ONCE = 2'b10,
    WAVE_PL_LOOP = 2'b11
  } wave_e;
endpackage

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  tc_reg,
  output wave_e             wave_reg,
  output logic              cmd_vld,
  output cmd_e              cmd
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_CNT_LO) lo_q <= wdata;
      if (addr == ADDR_CNT_HI) hi_q <= wdata;
    end
  end

  // R2: upper count bits sit below the mode field in the high byte
  assign tc_reg   = {hi_q[HI_W-1:0], lo_q};
  assign wave_reg = wave_e'(hi_q[BYTE_W-1 -: FLD_W]);
  assign cmd_vld  = wr_en && (addr == ADDR_CMD);
  assign cmd      = cmd_e'(wdata[BYTE_W-1 -: FLD_W]);
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
  import ptimer_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int MIN_TC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] tc_reg,
  input  wave_e            wave_reg,
  input  logic             cmd_vld,
  input  cmd_e             cmd,
  output logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cur_tc,
  output wave_e            cur_mode
);
  localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(MIN_TC);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] tc_eff;
  logic reload_pend, stop_pend;
  logic start_now, halt_now, drain_now, at_tc, do_reload, do_stop;

  assign tc_eff    = (tc_reg < TC_FLOOR) ? TC_FLOOR : tc_reg;     // R10
  assign start_now = cmd_vld && (cmd == CMD_START);
  assign halt_now  = cmd_vld && (cmd == CMD_HALT);
  assign drain_now = cmd_vld && (cmd == CMD_DRAIN);
  assign at_tc     = running && tick && (cnt == ONE);
  // R12: a command in the terminal-count cycle overrides older pending ones
  assign do_reload = start_now || (reload_pend && !drain_now);
  assign do_stop   = drain_now || (stop_pend && !start_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running     <= 1'b0;
      cnt         <= '0;
      cur_tc      <= TC_FLOOR;
      cur_mode    <= WAVE_SQ_ONCE;
      reload_pend <= 1'b0;
      stop_pend   <= 1'b0;
    end else if (halt_now) begin
      running     <= 1'b0;
      reload_pend <= 1'b0;
      stop_pend   <= 1'b0;
    end else if (!running) begin
      if (start_now) begin
        running  <= 1'b1;
        cur_tc   <= tc_eff;
        cur_mode <= wave_reg;
        cnt      <= tc_eff;
      end
    end else if (at_tc) begin
      reload_pend <= 1'b0;
      stop_pend   <= 1'b0;
      if (do_reload) begin
        cur_tc   <= tc_eff;
        cur_mode <= wave_reg;
        cnt      <= tc_eff;
      end else if (do_stop || !cur_mode[0]) begin
        running <= 1'b0;
      end else begin
        cnt <= cur_tc;
      end
    end else begin
      if (tick) cnt <= cnt - ONE;
      if (start_now) begin
        reload_pend <= 1'b1;
        stop_pend   <= 1'b0;
      end
      if (drain_now) begin
        stop_pend   <= 1'b1;
        reload_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptimer_wave.sv
module ptimer_wave
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             running,
  input  wave_e            mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cur_tc,
  output logic             wave_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] low_span;
  assign low_span = cur_tc >> 1;

  always_comb begin
    if (!running)     wave_out = 1'b1;
    else if (mode[1]) wave_out = (cnt != ONE);        // low on the TC-th tick
    else              wave_out = (cnt > low_span);    // longer half first
  end
endmodule

// File: rtl/ptimer14.sv
module ptimer14
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              tmr_out
);
  logic [CNT_W-1:0] tc_reg, cnt, cur_tc;
  wave_e            wave_reg, cur_mode;
  logic             cmd_vld, running;
  cmd_e             cmd;

  ptimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tc_reg(tc_reg), .wave_reg(wave_reg), .cmd_vld(cmd_vld), .cmd(cmd)
  );

  ptimer_core #(.CNT_W(CNT_W), .MIN_TC(2)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tc_reg(tc_reg), .wave_reg(wave_reg),
    .cmd_vld(cmd_vld), .cmd(cmd), .running(running), .cnt(cnt),
    .cur_tc(cur_tc), .cur_mode(cur_mode)
  );

  ptimer_wave #(.CNT_W(CNT_W)) u_wave (
    .running(running), .mode(cur_mode), .cnt(cnt), .cur_tc(cur_tc),
    .wave_out(tmr_out)
  );
endmodule

// File: rtl/ptimer14_chk.sv
module ptimer14_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [7:0]       wdata,
  input logic             tmr_out,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cur_tc,
  input logic [1:0]       cur_mode
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> tmr_out);

  a_r6_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'b000 && wdata[7:6] == 2'b01) |=> (tmr_out && !running));

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(tmr_out) && $stable(cnt)));

  a_r5_pulse_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cur_mode[1] && !tmr_out && tick) |=> tmr_out);

  a_r10_count_window: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cur_tc >= CNT_W'(2) && cnt >= CNT_W'(1) && cnt <= cur_tc));
endmodule

bind ptimer14 ptimer14_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_ptimer14.sv
module tb_ptimer14;
  localparam logic [2:0] A_CMD = 3'b000, A_LO = 3'b100, A_HI = 3'b101;
  localparam int NVEC = 8;
  // {mode[1:0], count[13:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'b00, 14'd5}, {2'b01, 14'd6}, {2'b01, 14'd7}, {2'b10, 14'd4},
    {2'b11, 14'd3}, {2'b01, 14'd0}, {2'b11, 14'd1}, {2'b00, 14'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic tmr_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ptimer14 dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                .addr(addr), .wdata(wdata), .tmr_out(tmr_out));

  function automatic logic expbit(input logic [1:0] m, input int t, input int i);
    int ph;
    if (i >= t && !m[0]) return 1'b1;
    ph = i % t;
    if (m[1]) return (ph != t - 1);
    return (ph < t - t / 2);
  endfunction

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (tmr_out !== exp) begin
      fails++;
      $display("FAIL %s: tmr_out=%0b expected %0b at %0t", tag, tmr_out, exp, $time);
    end
  endtask

  // one clock cycle: drive at negedge, sample at the next negedge
  task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d,
                     input logic exp, input string tag);
    wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(exp, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b1, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b1, "R1 after reset");

    // table walk: R2, R3, R4, R5, R10
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]  m;
      logic [13:0] t;
      int te;
      string tg;
      m  = VEC[v][15:14];
      t  = VEC[v][13:0];
      te = (t < 2) ? 2 : int'(t);
      tg = (t < 2) ? "R10" : (m[1] ? "R5" : "R3/R4");
      cyc(1, A_LO, t[7:0], 1'b1, "R2");
      cyc(1, A_HI, {m, t[13:8]}, 1'b1, "R2");
      cyc(1, A_CMD, 8'hC0, expbit(m, te, 0), tg);
      for (int i = 1; i < 2 * te; i++) cyc(0, A_CMD, 8'h00, expbit(m, te, i), tg);
      cyc(1, A_CMD, 8'h40, 1'b1, "R6 halt");
    end

    // R9 / R8: writes mid-run, start while running
    cyc(1, A_LO, 8'd6, 1, "R2");
    cyc(1, A_HI, 8'h40, 1, "R2");
    cyc(1, A_CMD, 8'hC0, 1, "R3");
    cyc(0, A_CMD, 8'h00, 1, "R3");
    cyc(0, A_CMD, 8'h00, 1, "R3");
    cyc(1, A_LO, 8'd4, 0, "R9");
    cyc(1, A_HI, 8'hC0, 0, "R9");
    cyc(0, A_CMD, 8'h00, 0, "R9");
    cyc(0, A_CMD, 8'h00, 1, "R9 old period kept");
    cyc(0, A_CMD, 8'h00, 1, "R9");
    cyc(0, A_CMD, 8'h00, 1, "R9");
    cyc(1, A_CMD, 8'hC0, 0, "R8 start while running");
    cyc(0, A_CMD, 8'h00, 0, "R9");
    cyc(0, A_CMD, 8'h00, 0, "R9");
    for (int r = 0; r < 2; r++) begin
      cyc(0, A_CMD, 8'h00, 1, "R8 reload");
      cyc(0, A_CMD, 8'h00, 1, "R8 reload");
      cyc(0, A_CMD, 8'h00, 1, "R8 reload");
      cyc(0, A_CMD, 8'h00, 0, "R8 reload pulse");
    end

    // R7: finish period then idle
    cyc(0, A_CMD, 8'h00, 1, "R7");
    cyc(1, A_CMD, 8'h80, 1, "R7");
    cyc(0, A_CMD, 8'h00, 1, "R7");
    cyc(0, A_CMD, 8'h00, 0, "R7 last pulse");
    for (int i = 0; i < 5; i++) cyc(0, A_CMD, 8'h00, 1, "R7 idle");

    // R6: no-op command and halt
    cyc(1, A_LO, 8'd4, 1, "R2");
    cyc(1, A_HI, 8'h40, 1, "R2");
    cyc(1, A_CMD, 8'hC0, 1, "R6");
    cyc(1, A_CMD, 8'h00, 1, "R6 nop");
    cyc(0, A_CMD, 8'h00, 0, "R6 nop");
    cyc(0, A_CMD, 8'h00, 0, "R6 nop");
    cyc(0, A_CMD, 8'h00, 1, "R6 nop");
    cyc(0, A_CMD, 8'h00, 1, "R6 nop");
    cyc(1, A_CMD, 8'h40, 1, "R6 halt");
    for (int i = 0; i < 4; i++) cyc(0, A_CMD, 8'h00, 1, "R6 halted");

    // R11: tick gating
    cyc(1, A_CMD, 8'hC0, 1, "R11");
    cyc(0, A_CMD, 8'h00, 1, "R11");
    tick = 1'b0;
    for (int i = 0; i < 4; i++) cyc(0, A_CMD, 8'h00, 1, "R11 frozen");
    tick = 1'b1;
    cyc(0, A_CMD, 8'h00, 0, "R11 resumed");
    cyc(0, A_CMD, 8'h00, 0, "R11");
    cyc(0, A_CMD, 8'h00, 1, "R11");
    cyc(1, A_CMD, 8'h40, 1, "R6 halt");

    // R12: commands on the terminal-count edge
    cyc(1, A_LO, 8'd4, 1, "R2");
    cyc(1, A_HI, 8'h00, 1, "R2");
    cyc(1, A_CMD, 8'hC0, 1, "R4");
    cyc(1, A_LO, 8'd2, 1, "R9");
    cyc(1, A_HI, 8'hC0, 0, "R9");
    cyc(0, A_CMD, 8'h00, 0, "R4");
    cyc(1, A_CMD, 8'hC0, 1, "R12 start at tc");
    cyc(0, A_CMD, 8'h00, 0, "R12 reloaded pulse");
    cyc(0, A_CMD, 8'h00, 1, "R12");
    cyc(0, A_CMD, 8'h00, 0, "R12");
    cyc(1, A_CMD, 8'h40, 1, "R12 halt at tc");
    for (int i = 0; i < 3; i++) cyc(0, A_CMD, 8'h00, 1, "R12 halted");
    cyc(1, A_CMD, 8'hC0, 1, "R12");
    cyc(0, A_CMD, 8'h00, 0, "R12");
    cyc(1, A_CMD, 8'h80, 1, "R12 drain at tc");
    for (int i = 0; i < 3; i++) cyc(0, A_CMD, 8'h00, 1, "R12 drained");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule